// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This controller sits beside a memory whose volatile array is backed cell for cell by a nonvolatile shadow copy. It decides when the whole array is copied into the shadow copy (a store) and when the shadow copy is loaded back into the array (a recall). It issues one-cycle start strobes to the bulk copy engines and keeps the access logic out of the array while either copy runs. It also times every operation itself, in clock cycles set by parameters.

Three inputs drive it. A low-supply indication starts a recall when the supply comes back, and it also starts an attempted store when the supply falls. A shared active-low request/busy line works in open-drain fashion: any party can pull it low to ask for a store, and the controller pulls it low itself while it is storing. The access logic sends a pulse each time an array write completes. A store is started only if at least one write has completed since the last store or recall ended. An external request first allows a grace window in which reads go on and a write in flight can finish. After a request, the block stays locked until the line is seen high again.

Both raw inputs pass through two-flop synchronizers. The controller drives the shared line only through an enable: it either pulls the line low or releases it, and it reads the line's real level back on a separate input. That way a board driver that holds the line high can veto an automatic store.

Top module: `nvs_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the synchronized supply indication reads good, `inhibit_o`=1, `wr_block_o`=1, `ready_o`=0 and `busy_drive_o`=0. The supply is assumed low out of reset.
- R2: When the supply indication goes good (`supply_low_i`=0), `recall_start_o` pulses once. `ready_o` rises exactly RECALL_CYC cycles after the sample in which the pulse is seen, and `inhibit_o` stays 1 for that whole window.
- R3: A completed write (`write_done_i`=1 for one cycle) marks the array dirty. A store or a recall that runs to its end clears the mark. `store_start_o` pulses only while the mark is set, so a request made while the array is clean starts no store.
- R4: When `line_i` is pulled low while the block is ready, there are exactly GRACE_CYC cycles in which `wr_block_o`=1 and `inhibit_o`=0. Reads stay allowed in this window, and a write that completes inside it still marks the array dirty.
- R5: A store holds `busy_drive_o`=1 and `inhibit_o`=1 from its `store_start_o` cycle for exactly STORE_CYC cycles, and then releases the line.
- R6: After an external request has been handled, whether a store ran or was skipped, `ready_o`=0 and `inhibit_o`=1 until `line_i` is seen high again. About three cycles after release, `ready_o` returns to 1.
- R7: If the supply falls while the array is dirty, the block drives the line low. If the line reads back low, a store of STORE_CYC cycles follows: three probe cycles plus STORE_CYC of drive. If the line still reads high after PROBE_CYC cycles, the attempt is abandoned with no `store_start_o`.
- R8: If the supply falls while the array is clean, no store is started and the line is not driven. The block sits with `inhibit_o`=1 and `ready_o`=0 waiting for the supply to return.
- R9: A pull on `line_i` during a recall is ignored: no grace window and no store follow it, and the recall runs to its normal end.
- R10: `ready_o`=1 only when neither `inhibit_o` nor `wr_block_o` is set, and the two start strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_i | input | 1 | Raw low-supply indication, 1 = below threshold |
| line_i | input | 1 | Sampled level of the shared active-low request/busy line |
| write_done_i | input | 1 | One-cycle pulse per completed array write |
| busy_drive_o | output | 1 | 1 = pull the shared line low, 0 = release |
| store_start_o | output | 1 | One-cycle strobe starting the bulk store engine |
| recall_start_o | output | 1 | One-cycle strobe starting the bulk recall engine |
| inhibit_o | output | 1 | Blocks array reads and writes |
| wr_block_o | output | 1 | Blocks newly requested array writes |
| ready_o | output | 1 | Array open for normal access |

## Verification
The bench builds the block with STORE_CYC=40, RECALL_CYC=20, GRACE_CYC=10 and PROBE_CYC=4 rather than the millisecond-scale defaults. With these values each store, recall and grace window can be counted to the exact cycle, and one run covers several full power-down and power-up cycles. The short probe window keeps the abandoned automatic store within reach: a modelled board driver holds the line high and overrides the block's pull. PROBE_CYC=4 sits just above the three cycles the read-back path needs, which shows the probe succeeds at the earliest point it can.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_GRACE  = 3'd3,
    ST_PROBE  = 3'd4,
    ST_STORE  = 3'd5,
    ST_LOCK   = 3'd6
  } nvs_state_e;

  function automatic int nvs_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic out_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[i];
        out_q  <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        out_q  <= meta_q;
      end
    end
    assign q_o[i] = out_q;
  end

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/nvs_dirty.sv
module nvs_dirty (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign dirty_o = flag_q;

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int STORE_CYC  = 500000,
  parameter int RECALL_CYC = 27500,
  parameter int GRACE_CYC  = 50000,
  parameter int PROBE_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic line_i,
  input  logic write_done_i,
  output logic busy_drive_o,
  output logic store_start_o,
  output logic recall_start_o,
  output logic inhibit_o,
  output logic wr_block_o,
  output logic ready_o
);

  localparam int MAXC = nvs_max4(STORE_CYC, RECALL_CYC, GRACE_CYC, PROBE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  // bit 1: supply low, bit 0: line level; both assumed idle-high / low-supply at reset
  logic [1:0] raw_in;
  logic [1:0] syn_q;
  logic       low_s;
  logic       line_s;

  assign raw_in = {supply_low_i, line_i};

  nvs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_q)
  );

  assign low_s  = syn_q[1];
  assign line_s = syn_q[0];

  nvs_state_e    state_q, state_n;
  logic          t_done;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          dirty_q;
  logic          dirty_clr;

  nvs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  nvs_dirty u_dirty (
    .clk     (clk),
    .rst     (rst),
    .set_i   (write_done_i),
    .clr_i   (dirty_clr),
    .dirty_o (dirty_q)
  );

  // next-state decision
  always_comb begin
    state_n   = state_q;
    dirty_clr = 1'b0;
    unique case (state_q)
      ST_DOWN: begin
        if (!low_s) state_n = ST_RECALL;
      end
      ST_RECALL: begin
        if (low_s) begin
          state_n = ST_DOWN;
        end else if (t_done) begin
          state_n   = ST_IDLE;
          dirty_clr = 1'b1;
        end
      end
      ST_IDLE: begin
        if (low_s)        state_n = dirty_q ? ST_PROBE : ST_DOWN;
        else if (!line_s) state_n = ST_GRACE;
      end
      ST_GRACE: begin
        if (low_s)       state_n = dirty_q ? ST_PROBE : ST_DOWN;
        else if (t_done) state_n = dirty_q ? ST_STORE : ST_LOCK;
      end
      ST_PROBE: begin
        if (!line_s)     state_n = ST_STORE;
        else if (t_done) state_n = ST_DOWN;
      end
      ST_STORE: begin
        if (t_done) begin
          dirty_clr = 1'b1;
          state_n   = low_s ? ST_DOWN : ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (low_s)       state_n = ST_DOWN;
        else if (line_s) state_n = ST_IDLE;
      end
      default: state_n = ST_DOWN;
    endcase
  end

  // window length loaded on entry to a timed state
  always_comb begin
    t_load = (state_n != state_q);
    unique case (state_n)
      ST_RECALL: t_val = CW'(RECALL_CYC - 1);
      ST_GRACE:  t_val = CW'(GRACE_CYC - 1);
      ST_PROBE:  t_val = CW'(PROBE_CYC - 1);
      ST_STORE:  t_val = CW'(STORE_CYC - 1);
      default:   t_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_DOWN;
      busy_drive_o   <= 1'b0;
      store_start_o  <= 1'b0;
      recall_start_o <= 1'b0;
      inhibit_o      <= 1'b1;
      wr_block_o     <= 1'b1;
      ready_o        <= 1'b0;
    end else begin
      state_q        <= state_n;
      busy_drive_o   <= (state_n == ST_PROBE) || (state_n == ST_STORE);
      store_start_o  <= (state_n == ST_STORE)  && (state_q != ST_STORE);
      recall_start_o <= (state_n == ST_RECALL) && (state_q != ST_RECALL);
      inhibit_o      <= (state_n != ST_IDLE) && (state_n != ST_GRACE);
      wr_block_o     <= (state_n != ST_IDLE);
      ready_o        <= (state_n == ST_IDLE);
    end
  end

endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk (
  input logic clk,
  input logic rst,
  input logic busy_drive_o,
  input logic store_start_o,
  input logic recall_start_o,
  input logic inhibit_o,
  input logic wr_block_o,
  input logic ready_o,
  input logic dirty_q
);

  a_r10_ready_open: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!inhibit_o && !wr_block_o));

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(store_start_o && recall_start_o));

  a_r3_store_needs_dirty: assert property (@(posedge clk) disable iff (rst)
    store_start_o |-> dirty_q);

  a_r5_store_drives_line: assert property (@(posedge clk) disable iff (rst)
    store_start_o |-> (busy_drive_o && inhibit_o));

  a_r5_busy_blocks_array: assert property (@(posedge clk) disable iff (rst)
    busy_drive_o |-> inhibit_o);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    store_start_o |=> !store_start_o);

  a_r2_recall_holds_off: assert property (@(posedge clk) disable iff (rst)
    recall_start_o |=> (inhibit_o && !ready_o && !busy_drive_o));

endmodule

bind nvs_seq nvs_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .busy_drive_o   (busy_drive_o),
  .store_start_o  (store_start_o),
  .recall_start_o (recall_start_o),
  .inhibit_o      (inhibit_o),
  .wr_block_o     (wr_block_o),
  .ready_o        (ready_o),
  .dirty_q        (dirty_q)
);

// File: tb/nvs_seq_tb.sv
`timescale 1ns/1ps
module nvs_seq_tb;

  localparam int STORE  = 40;
  localparam int RECALL = 20;
  localparam int GRACE  = 10;
  localparam int PROBE  = 4;
  localparam int PROBE_SEEN = 3;  // drive reg + two synchronizer flops

  // [4] write first, [3] external request (else supply drop),
  // [2] board holds line high, [1] write inside grace, [0] store expected
  localparam logic [4:0] VEC [6] = '{
    5'b11001, 5'b01000, 5'b01011, 5'b10001, 5'b10100, 5'b00000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b1;
  logic ext_pull = 1'b0;
  logic hold_high = 1'b0;
  logic write_done = 1'b0;
  logic line;
  logic busy_drive, store_start, recall_start, inhibit, wr_block, ready;

  int checks = 0;
  int errors = 0;
  int n_store = 0, n_recall = 0, n_busy = 0, n_grace = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign line = hold_high ? 1'b1 : ~(busy_drive | ext_pull);

  nvs_seq #(
    .STORE_CYC(STORE), .RECALL_CYC(RECALL), .GRACE_CYC(GRACE), .PROBE_CYC(PROBE)
  ) u_dut (
    .clk(clk), .rst(rst), .supply_low_i(supply_low), .line_i(line),
    .write_done_i(write_done), .busy_drive_o(busy_drive),
    .store_start_o(store_start), .recall_start_o(recall_start),
    .inhibit_o(inhibit), .wr_block_o(wr_block), .ready_o(ready)
  );

  always @(posedge clk) begin
    #1;
    n_store  += int'(store_start);
    n_recall += int'(recall_start);
    n_busy   += int'(busy_drive);
    n_grace  += int'(wr_block && !inhibit);
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_recall();
    int k = 0;
    int guard = 0;
    while (!recall_start && guard < 50) begin tick(); guard++; end
    chk(recall_start, "R2 recall strobe", int'(recall_start), 1);
    while (!ready && k < RECALL + 20) begin tick(); k++; end
    chk(k == RECALL, "R2 recall length", k, RECALL);
  endtask

  task automatic run_vec(input logic [4:0] v, input int idx);
    int s0, b0, g0, exp_busy;
    if (v[4]) begin write_done = 1'b1; tick(); write_done = 1'b0; tick(); end
    s0 = n_store; b0 = n_busy; g0 = n_grace;
    if (v[3]) begin
      ext_pull = 1'b1;
      if (v[1]) begin
        repeat (5) tick();
        write_done = 1'b1; tick(); write_done = 1'b0;
      end
      repeat (GRACE + STORE + 20) tick();
      chk(!ready && inhibit, "R6 locked while line low", int'(ready), 0);
      chk(n_store - s0 == int'(v[0]), "R3 store only when dirty", n_store - s0, int'(v[0]));
      chk(n_grace - g0 == GRACE, "R4 grace window", n_grace - g0, GRACE);
      if (v[0]) chk(n_busy - b0 == STORE, "R5 store drive length", n_busy - b0, STORE);
      ext_pull = 1'b0;
      repeat (8) tick();
      chk(ready, "R6 ready after release", int'(ready), 1);
    end else begin
      hold_high = v[2];
      supply_low = 1'b1;
      repeat (PROBE + STORE + 20) tick();
      exp_busy = v[0] ? PROBE_SEEN + STORE : (v[4] ? PROBE : 0);
      chk(n_store - s0 == int'(v[0]), "R7 supply-drop store", n_store - s0, int'(v[0]));
      chk(n_busy - b0 == exp_busy, v[4] ? "R7 probe and drive" : "R8 clean no drive",
          n_busy - b0, exp_busy);
      chk(inhibit && !ready, "R8 waits for supply", int'(ready), 0);
      supply_low = 1'b0;
      hold_high = 1'b0;
      wait_recall();
    end
    if (idx < 0) $display("unreachable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, g0;
    repeat (4) tick();
    chk(inhibit && wr_block && !ready && !busy_drive, "R1 reset outputs", int'(ready), 0);
    rst = 1'b0;
    repeat (6) tick();
    chk(inhibit && !ready && n_recall == 0, "R1 held while supply low", n_recall, 0);
    chk(wr_block, "R1 writes blocked", int'(wr_block), 1);

    supply_low = 1'b0;
    wait_recall();
    chk(!wr_block && !inhibit, "R10 ready opens array", int'(inhibit), 0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i], i);

    // R9: request line pulled during a recall is ignored
    write_done = 1'b1; tick(); write_done = 1'b0;
    hold_high = 1'b1; supply_low = 1'b1;
    repeat (20) tick();
    supply_low = 1'b0; hold_high = 1'b0;
    s0 = n_store; g0 = n_grace;
    begin
      int guard = 0;
      while (!recall_start && guard < 50) begin tick(); guard++; end
    end
    ext_pull = 1'b1; repeat (4) tick(); ext_pull = 1'b0;
    repeat (RECALL + 10) tick();
    chk(n_store == s0, "R9 no store from request in recall", n_store - s0, 0);
    chk(n_grace == g0, "R9 no grace from request in recall", n_grace - g0, 0);
    chk(ready, "R9 recall completes", int'(ready), 1);

    // R3: recall cleared the write mark, so an external request stores nothing
    s0 = n_store;
    ext_pull = 1'b1; repeat (GRACE + 10) tick(); ext_pull = 1'b0;
    repeat (8) tick();
    chk(n_store == s0, "R3 recall clears mark", n_store - s0, 0);
    chk(ready, "R6 ready after skipped store", int'(ready), 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule